// File: doc/BRIEF.md
# Network Controller Indirect Register Block

This block is the host-facing register window of a network controller. The host sees only two 16-bit word ports. One holds a register selector. The other reads or writes whichever of four control/status words that selector points at. Word 0 is the main control/status word. Words 1 and 2 together hold a 32-bit pointer to the controller's initialisation structure in memory. Word 3 is plain storage.

The control/status word combines several kinds of bit behaviour. It has a stop command that overrides everything else. It has status flags that the host clears by writing a one to them. It has an error summary bit and an interrupt summary bit that are recomputed on each write. It has an interrupt enable bit that takes the written value directly. It has an init command and a start command, and init wins when both are written.

The receive and transmit engines sit outside this block. Each one reports a finished frame with a one-cycle event pulse, and that pulse raises a status flag together with the interrupt summary bit. The interrupt output is high while the summary bit and the enable bit are both set.

Top module: `nic_csr_regs`

## Requirements
- R1: The word port is chosen by byte-address bit 1. Addresses 0 and 1 reach the data port. Addresses 2 and 3 reach the selector port.
- R2: A selector write is accepted only if the value is below 4. Otherwise the old selection is kept. A selector read returns the current selection, zero-extended.
- R3: A control-word write with bit 2 set makes the word exactly 0x0004, whatever the other written bits are.
- R4: In any other control-word write, each written 1 in bits 14..8 clears the matching bit.
- R5: After the clears, bit 15 is set to the OR of the bits under mask 0x7100, and bit 7 is set to the OR of bits 14..8. This happens before the command bits are applied, so the bit 8 that an init command sets is not reflected in bit 15 or bit 7 until the next write.
- R6: In a non-stop control-word write, bit 6 takes the written value.
- R7: In a non-stop write, a written bit 0 sets bits 8 and 0 and clears bit 2. Otherwise a written bit 1 sets bits 1, 5 and 4 and clears bit 2. Bit 0 has priority over bit 1.
- R8: A write to word 1 loads init_ptr[15:0], and a write to word 2 loads init_ptr[31:16]. Word 3 only stores its value. Data-port reads of words 1 to 3 return the stored values.
- R9: After reset the control word is 0x0004, words 1 to 3 are 0 and the selection is 0.
- R10: irq is high exactly while control-word bits 7 and 6 are both 1.
- R11: A rx_evt pulse sets bits 10 and 7, and a tx_evt pulse sets bits 9 and 7, at the same clock edge, on top of any same-cycle write. Events are dropped while bit 2 is already set, and they are also dropped when a same-cycle write sets bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Byte address of the word port |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from bus_addr) |
| rx_evt | input | 1 | Receive-complete event pulse |
| tx_evt | input | 1 | Transmit-complete event pulse |
| irq | output | 1 | Interrupt request |
| init_ptr | output | 32 | Initialisation structure pointer |

## Verification
Every register state change is visible on the next data-port read, one clock after the write. A wrong control-word bit therefore shows up on bus_rdata at once, and often on irq in that same cycle. A bad selector update shows up as a data-port read from the wrong word, or as a wrong selector readback. A summary bit computed in the wrong order shows up only after an init command followed by a later write, so the bench runs exactly that sequence. It also sweeps command, enable, clear and stop bit combinations from a state where flags are set.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
    localparam int WORD_W   = 16;
    localparam int NUM_REGS = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);

    typedef enum logic [0:0] {
        PORT_DATA = 1'b0,
        PORT_SEL  = 1'b1
    } port_e;

    // bit positions of the control word
    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TXON = 4;
    localparam int B_RXON = 5;
    localparam int B_INEA = 6;
    localparam int B_INTR = 7;
    localparam int B_IDON = 8;
    localparam int B_TINT = 9;
    localparam int B_RINT = 10;
    localparam int B_ERR  = 15;

    localparam logic [WORD_W-1:0] STOP_ONLY    = 16'h0004;
    localparam logic [WORD_W-1:0] CLEAR_MASK   = 16'h7f00;
    localparam logic [WORD_W-1:0] ERR_SRC_MASK = 16'h7100;

    localparam int PTR_LO_IDX = 1;
    localparam int PTR_HI_IDX = 2;

    // next control word for a host write
    function automatic logic [WORD_W-1:0] ctl_after_write(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] val
    );
        logic [WORD_W-1:0] r;
        r = cur & ~(val & CLEAR_MASK);
        r[B_ERR]  = |(r & ERR_SRC_MASK);
        r[B_INTR] = |(r & CLEAR_MASK);
        r[B_INEA] = val[B_INEA];
        if (val[B_INIT]) begin
            r[B_IDON] = 1'b1;
            r[B_INIT] = 1'b1;
            r[B_STOP] = 1'b0;
        end else if (val[B_STRT]) begin
            r[B_STRT] = 1'b1;
            r[B_RXON] = 1'b1;
            r[B_TXON] = 1'b1;
            r[B_STOP] = 1'b0;
        end
        if (val[B_STOP]) r = STOP_ONLY;
        return r;
    endfunction
endpackage

// File: rtl/nic_port_decode.sv
module nic_port_decode
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output port_e             port,
    output logic              wr_data,
    output logic [SEL_W-1:0]  sel_q
);
    logic unused_addr_lsb;
    logic sel_ok;

    assign unused_addr_lsb = addr[0];
    assign port    = port_e'(addr[1]);
    assign wr_data = wr && (port == PORT_DATA);
    assign sel_ok  = (wdata < WORD_W'(NUM_REGS));

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (wr && port == PORT_SEL && sel_ok)
            sel_q <= wdata[SEL_W-1:0];
    end

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr[1] && wdata >= 16'd4) |=> $stable(sel_q));

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr[1] && wdata < 16'd4) |=> (sel_q == $past(wdata[SEL_W-1:0])));
endmodule

// File: rtl/nic_ctl_word.sv
module nic_ctl_word
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rx_evt,
    input  logic              tx_evt,
    output logic [WORD_W-1:0] ctl_q
);
    logic [WORD_W-1:0] nxt;
    logic              evt_ok;

    always_comb begin
        nxt    = ctl_q;
        evt_ok = !ctl_q[B_STOP];
        if (wr) begin
            nxt = ctl_after_write(ctl_q, wdata);
            if (wdata[B_STOP]) evt_ok = 1'b0;
        end
        if (evt_ok && rx_evt) begin
            nxt[B_RINT] = 1'b1;
            nxt[B_INTR] = 1'b1;
        end
        if (evt_ok && tx_evt) begin
            nxt[B_TINT] = 1'b1;
            nxt[B_INTR] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= STOP_ONLY;
        else     ctl_q <= nxt;
    end

    // R3
    stop_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[2]) |=> (ctl_q == 16'h0004));

    // R6
    enable_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata[2]) |=> (ctl_q[6] == $past(wdata[6])));

    // R7
    init_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata[2] && wdata[0]) |=> (ctl_q[8] && ctl_q[0] && !ctl_q[2]));

    // R11
    rx_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_evt && !ctl_q[2] && !(wr && wdata[2])) |=> (ctl_q[10] && ctl_q[7]));

    // R11
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr && ctl_q[2]) |=> $stable(ctl_q));
endmodule

// File: rtl/nic_aux_regs.sv
module nic_aux_regs
    import nic_csr_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr,
    input  logic [SEL_W-1:0]                    sel,
    input  logic [WORD_W-1:0]                   wdata,
    output logic [NUM_REGS-1:1][WORD_W-1:0]     aux_q,
    output logic [2*WORD_W-1:0]                 init_ptr
);
    for (genvar k = 1; k < NUM_REGS; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                aux_q[k] <= '0;
            else if (wr && sel == SEL_W'(k))
                aux_q[k] <= wdata;
        end
    end

    assign init_ptr = {aux_q[PTR_HI_IDX], aux_q[PTR_LO_IDX]};

    // R8
    ptr_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == 2'd1) |=> (init_ptr[15:0] == $past(wdata)));

    // R8
    ptr_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == 2'd2) |=> (init_ptr[31:16] == $past(wdata)));
endmodule

// File: rtl/nic_csr_regs.sv
module nic_csr_regs
    import nic_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rx_evt,
    input  logic        tx_evt,
    output logic        irq,
    output logic [31:0] init_ptr
);
    port_e                            port;
    logic                             wr_data;
    logic [SEL_W-1:0]                 sel_q;
    logic [WORD_W-1:0]                ctl_q;
    logic [NUM_REGS-1:1][WORD_W-1:0]  aux_q;
    logic [NUM_REGS-1:0][WORD_W-1:0]  all_q;

    nic_port_decode u_dec (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .port(port), .wr_data(wr_data), .sel_q(sel_q)
    );

    nic_ctl_word u_ctl (
        .clk(clk), .rst(rst), .wr(wr_data && sel_q == '0), .wdata(bus_wdata),
        .rx_evt(rx_evt), .tx_evt(tx_evt), .ctl_q(ctl_q)
    );

    nic_aux_regs u_aux (
        .clk(clk), .rst(rst), .wr(wr_data), .sel(sel_q), .wdata(bus_wdata),
        .aux_q(aux_q), .init_ptr(init_ptr)
    );

    assign all_q = {aux_q, ctl_q};
    assign irq   = ctl_q[B_INTR] && ctl_q[B_INEA];

    always_comb begin
        if (port == PORT_SEL) bus_rdata = WORD_W'(sel_q);
        else                  bus_rdata = all_q[sel_q];
    end

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr[1] && sel_q == '0 && !bus_wdata[6]) |=> !irq);
endmodule

// File: tb/nic_csr_regs_test.sv
module nic_csr_regs_test;
    logic        clk = 0;
    logic        rst = 1;
    logic [1:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic        rx_evt = 0, tx_evt = 0;
    logic        irq;
    logic [31:0] init_ptr;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nic_csr_regs uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_evt(rx_evt),
        .tx_evt(tx_evt), .irq(irq), .init_ptr(init_ptr)
    );

    function automatic logic [15:0] model_wr(input logic [15:0] c, input logic [15:0] v);
        logic [15:0] r;
        if (v[2]) return 16'h0004;
        r = c & ~(v & 16'h7f00);
        r[15] = (r[14:12] != 0) || r[8];
        r[7]  = (r[14:8] != 0);
        r[6]  = v[6];
        if (v[0]) r = (r | 16'h0101) & ~16'h0004;
        else if (v[1]) r = (r | 16'h0032) & ~16'h0004;
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input bit rx, input bit tx);
        @(negedge clk);
        rx_evt = rx; tx_evt = tx;
        @(negedge clk);
        rx_evt = 0; tx_evt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] m;
        logic [15:0] v;
        int pos[9] = '{0, 1, 2, 4, 6, 8, 9, 10, 15};

        do_reset();
        // R9 reset state
        rd(2'd0, d); check("R9 ctl", d, 16'h0004);
        rd(2'd2, d); check("R9 sel", d, 0);
        check("R9 ptr", init_ptr, 0);
        check("R10 irq reset", irq, 0);
        for (int k = 1; k < 4; k++) begin
            wr(2'd2, 16'(k));
            rd(2'd0, d); check("R9 aux", d, 0);
        end

        // R2 selector bounds
        wr(2'd2, 16'd1);
        wr(2'd2, 16'd4);
        rd(2'd2, d); check("R2 reject 4", d, 1);
        wr(2'd2, 16'hffff);
        rd(2'd3, d); check("R2 reject ffff", d, 1);

        // R8 and R1 words
        wr(2'd1, 16'hbeef);
        check("R8 ptr lo", init_ptr, 32'h0000beef);
        wr(2'd3, 16'd2);
        rd(2'd2, d); check("R1 addr3 selects port", d, 2);
        wr(2'd0, 16'h1234);
        check("R8 ptr hi", init_ptr, 32'h1234beef);
        wr(2'd2, 16'd3);
        wr(2'd0, 16'h5a5a);
        rd(2'd1, d); check("R8 word3 via addr1", d, 16'h5a5a);
        check("R8 ptr untouched", init_ptr, 32'h1234beef);
        wr(2'd2, 16'd1);
        rd(2'd0, d); check("R8 word1 read", d, 16'hbeef);
        wr(2'd2, 16'd0);

        // R11 events ignored while stopped
        pulse(1, 1);
        rd(2'd0, d); check("R11 stopped ignore", d, 16'h0004);
        check("R10 irq stopped", irq, 0);

        // R5 ordering: init sets IDON without summaries
        wr(2'd0, 16'h0041);
        rd(2'd0, d); check("R5 init no summary", d, 16'h0141);
        check("R10 irq after init", irq, 0);
        // R11 event combined with a write
        @(negedge clk);
        bus_addr = 0; bus_wdata = 16'h0040; bus_wr = 1; rx_evt = 1;
        @(negedge clk);
        bus_wr = 0; rx_evt = 0;
        rd(2'd0, d); check("R11 write plus event", d, 16'h85c1);
        check("R10 irq on", irq, 1);
        // R11 event dropped by a stop write
        @(negedge clk);
        bus_wdata = 16'h0004; bus_wr = 1; tx_evt = 1;
        @(negedge clk);
        bus_wr = 0; tx_evt = 0;
        rd(2'd0, d); check("R11 stop drops event", d, 16'h0004);

        // R3..R7, R10, R11 sweep
        for (int i = 0; i < 512; i++) begin
            v = 0;
            for (int b = 0; b < 9; b++) v[pos[b]] = i[b];
            wr(2'd0, 16'h0004);
            wr(2'd0, 16'h0042);
            pulse(1, 0);
            pulse(0, 1);
            m = model_wr(16'h0004, 16'h0042) | 16'h0680;
            rd(2'd0, d); check("R11 events set", d, m);
            wr(2'd0, v);
            m = model_wr(m, v);
            rd(2'd0, d);
            check(v[2] ? "R3 stop" : (v[0] ? "R7 init" : "R4 R5 R6 R7 write"), d, m);
            check("R10 irq", irq, m[7] & m[6]);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule